// File: doc/BRIEF.md
# Slave-side bus arbitration controller

This block decides which of four bus masters owns one slave port of a multi-layer bus matrix. Every master presents a request, its slave-select (HSEL), its transfer type (HTRANS), its burst type (HBURST) and its address. The top nibble of each address carries the master's priority level. The nibble below it carries the transfer length the master would like. One lock input (HMASTLOCK) and the shared HREADY complete the inputs.

When a decision is due, the controller looks at the priorities of the masters that are requesting. If they are all equal, it picks one by round-robin. If they differ, the highest priority wins. It then holds the grant for a number of data beats set by a run-time length mode. It outputs a one-hot grant, the granted index and a No-Port flag that is raised when no master owns the port. Both the priority policy (fixed table, round-robin, or dynamic from the address) and the length mode can be changed while the block is running. The data and address multiplexers and the slave itself are outside this block.

Top module: `ss_arb_ctrl`

## Requirements
- R1: Synchronous active-low reset drives `grant_o` to 0, `master_o` to 0 and `no_port_o` to 1. It also sets the round-robin pointer to master 0.
- R2: While no master is granted and `req_i` is all zero, `no_port_o` stays 1. A request while idle produces a grant at the next rising edge.
- R3: If the requesting masters' priority levels differ, the highest level wins, and among equals at that level the lower index wins. `policy_i`=0 (fixed) takes the levels from parameter `FIXED_PRIO` (default: master 0=4, 1=3, 2=2, 3=1). `policy_i`=2 or 3 (dynamic) takes them from address bits [31:28].
- R4: If all requesters have equal levels, the winner is the first requester at or after the round-robin pointer, in increasing index order with wrap. Every new grant moves the pointer to the granted index plus one, modulo 4. `policy_i`=1 treats all levels as equal.
- R5: While a master is granted and `hmastlock_i` is 1, the grant does not change. The beat counter keeps decrementing.
- R6: A new grant loads the beat counter with the winner's length. A beat is a cycle with `hready_i`=1 and the granted master's HTRANS equal to 2 (NONSEQ) or 3 (SEQ). While the counter is non-zero and the granted master's HSEL is 1, the grant is held and each beat lowers the counter by one.
- R7: Once the counter is zero and nobody requests, the granted master keeps the grant if its HSEL is 1. Otherwise the grant is dropped and `no_port_o` goes to 1.
- R8: Once the counter is zero and some master requests, a new arbitration is made and the counter is reloaded.
- R9: If the granted master's HSEL falls while the counter is non-zero, the block re-arbitrates when there are requesters. Otherwise it drops the grant and raises `no_port_o`.
- R10: The transfer length depends on `len_mode_i`. With 0 (per-transfer) it is 1. With 1 (per-burst) it comes from HBURST: 0 or 1 gives 1, 2 or 3 gives 4, 4 or 5 gives 8, 6 or 7 gives 16. With 2 or 3 (desired) it is address bits [27:24], where 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_i | input | 2 | Priority policy: 0 fixed, 1 round-robin, 2/3 dynamic |
| len_mode_i | input | 2 | Length mode: 0 per-transfer, 1 per-burst, 2/3 desired |
| req_i | input | 4 | Request per master |
| hsel_i | input | 4 | Slave select per master |
| hmastlock_i | input | 1 | Lock for the granted master |
| hready_i | input | 1 | Transfer completes this cycle |
| htrans_i | input | 8 | HTRANS per master, 2 bits each, master 0 lowest |
| hburst_i | input | 12 | HBURST per master, 3 bits each, master 0 lowest |
| haddr_i | input | 128 | Address per master, 32 bits each, master 0 lowest |
| grant_o | output | 4 | One-hot grant |
| master_o | output | 2 | Granted master index (0 when idle) |
| no_port_o | output | 1 | No master owns the port |

## Verification
The grant, index and No-Port outputs are registered. Each result is due at the first rising edge after the inputs that cause it, so an input applied in one cycle shows up exactly one cycle later. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge from the same inputs, and the design's three outputs are compared with the model at the next falling edge. This sampling point means a grant, a counter reload or a release is always checked in the cycle it is due, never one early or one late.

// File: rtl/ss_arb_pkg.sv
// Package: shared encodings and helpers for the slave-side arbiter.
// Assumes HTRANS/HBURST follow the usual 2-bit/3-bit bus encodings.
package ss_arb_pkg;

    localparam logic [1:0] POL_FIXED = 2'd0;
    localparam logic [1:0] POL_RR    = 2'd1;

    localparam logic [1:0] LM_XFER   = 2'd0;
    localparam logic [1:0] LM_BURST  = 2'd1;

    // Map a burst code onto its beat count; INCR (undefined) counts as 1.
    function automatic logic [4:0] burst_beats(input logic [2:0] code);
        case (code)
            3'd2, 3'd3: burst_beats = 5'd4;
            3'd4, 3'd5: burst_beats = 5'd8;
            3'd6, 3'd7: burst_beats = 5'd16;
            default:    burst_beats = 5'd1;
        endcase
    endfunction

endpackage

// File: rtl/ss_arb_len.sv
// Length source: per-master transfer length for the current length mode.
// Assumes the desired length sits in address bits [LEN_LSB+3:LEN_LSB].
module ss_arb_len #(
    parameter int NM      = 4,
    parameter int AW      = 32,
    parameter int CW      = 5,
    parameter int LEN_LSB = 24
) (
    input  logic [1:0]       len_mode_i,
    input  logic [NM*3-1:0]  hburst_i,
    input  logic [NM*AW-1:0] haddr_i,
    output logic [NM*CW-1:0] len_o
);
    import ss_arb_pkg::*;

    for (genvar g = 0; g < NM; g++) begin : g_len
        logic [3:0] want;
        assign want = haddr_i[g*AW+LEN_LSB +: 4];
        // Choose the reload value for master g.
        always_comb begin
            if (len_mode_i == LM_XFER)
                len_o[g*CW +: CW] = CW'(1);
            else if (len_mode_i == LM_BURST)
                len_o[g*CW +: CW] = CW'(burst_beats(hburst_i[g*3 +: 3]));
            else if (want == 4'd0)
                len_o[g*CW +: CW] = CW'(1);
            else
                len_o[g*CW +: CW] = CW'(want);
        end
    end

endmodule

// File: rtl/ss_arb_prio.sv
// Priority source: effective priority level of every master under the
// selected policy. Round-robin policy flattens all levels to zero.
module ss_arb_prio #(
    parameter int              NM         = 4,
    parameter int              AW         = 32,
    parameter int              PW         = 4,
    parameter int              PRIO_LSB   = 28,
    parameter logic [NM*PW-1:0] FIXED_PRIO = 16'h1234
) (
    input  logic [1:0]       policy_i,
    input  logic [NM*AW-1:0] haddr_i,
    output logic [NM*PW-1:0] prio_o
);
    import ss_arb_pkg::*;

    for (genvar g = 0; g < NM; g++) begin : g_prio
        // Select table, flat or address-carried level for master g.
        always_comb begin
            if (policy_i == POL_FIXED)
                prio_o[g*PW +: PW] = FIXED_PRIO[g*PW +: PW];
            else if (policy_i == POL_RR)
                prio_o[g*PW +: PW] = '0;
            else
                prio_o[g*PW +: PW] = haddr_i[g*AW+PRIO_LSB +: PW];
        end
    end

endmodule

// File: rtl/ss_arb_pick.sv
// Picker: chooses a winner among requesters. Equal levels -> round-robin
// from the pointer; otherwise highest level, lower index on ties.
module ss_arb_pick #(
    parameter int NM = 4,
    parameter int PW = 4,
    localparam int IW = $clog2(NM)
) (
    input  logic [NM-1:0]    req_i,
    input  logic [NM*PW-1:0] prio_i,
    input  logic [IW-1:0]    ptr_i,
    output logic             vld_o,
    output logic [IW-1:0]    idx_o
);
    logic [PW-1:0] best_p, first_p;
    logic [IW-1:0] best_i, rr_i;
    logic          seen, all_eq, rr_f;

    // Scan requesters for the top level and for level equality.
    always_comb begin
        best_p  = '0;
        first_p = '0;
        best_i  = '0;
        seen    = 1'b0;
        all_eq  = 1'b1;
        for (int i = 0; i < NM; i++) begin
            if (req_i[i]) begin
                if (!seen) begin
                    seen    = 1'b1;
                    first_p = prio_i[i*PW +: PW];
                    best_p  = prio_i[i*PW +: PW];
                    best_i  = IW'(i);
                end else begin
                    if (prio_i[i*PW +: PW] != first_p) all_eq = 1'b0;
                    if (prio_i[i*PW +: PW] > best_p) begin
                        best_p = prio_i[i*PW +: PW];
                        best_i = IW'(i);
                    end
                end
            end
        end
    end

    // Round-robin search starting at the pointer.
    always_comb begin
        rr_i = '0;
        rr_f = 1'b0;
        for (int k = 0; k < NM; k++) begin
            int j;
            j = int'(ptr_i) + k;
            if (j >= NM) j = j - NM;
            if (!rr_f && req_i[j]) begin
                rr_f = 1'b1;
                rr_i = IW'(j);
            end
        end
    end

    assign vld_o = seen;
    assign idx_o = all_eq ? rr_i : best_i;

endmodule

// File: rtl/ss_arb_ctrl.sv
// Slave-side arbitration controller (top). Holds the grant state, the
// beat counter and the round-robin pointer and applies the hold, lock,
// expiry and early-release rules. Outputs are registered.
// Assumes one HSEL/HTRANS/HBURST/address set per master.
module ss_arb_ctrl #(
    parameter int               NM         = 4,
    parameter int               AW         = 32,
    parameter int               PW         = 4,
    parameter int               CW         = 5,
    parameter logic [NM*PW-1:0] FIXED_PRIO = 16'h1234,
    localparam int              IW         = $clog2(NM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       policy_i,
    input  logic [1:0]       len_mode_i,
    input  logic [NM-1:0]    req_i,
    input  logic [NM-1:0]    hsel_i,
    input  logic             hmastlock_i,
    input  logic             hready_i,
    input  logic [NM*2-1:0]  htrans_i,
    input  logic [NM*3-1:0]  hburst_i,
    input  logic [NM*AW-1:0] haddr_i,
    output logic [NM-1:0]    grant_o,
    output logic [IW-1:0]    master_o,
    output logic             no_port_o
);
    localparam int PRIO_LSB = AW - PW;
    localparam int LEN_LSB  = AW - PW - 4;

    logic             cur_vld, nx_vld;
    logic [IW-1:0]    cur_idx, nx_idx;
    logic [CW-1:0]    cnt, nx_cnt, cnt_dec;
    logic [IW-1:0]    rr_ptr, nx_ptr;
    logic [NM*PW-1:0] prio;
    logic [NM*CW-1:0] len_all;
    logic             pick_vld, take, beat, cur_hsel;
    logic [IW-1:0]    pick_idx;
    logic [1:0]       cur_trans;

    ss_arb_prio #(.NM(NM), .AW(AW), .PW(PW), .PRIO_LSB(PRIO_LSB),
                  .FIXED_PRIO(FIXED_PRIO)) prio_i (
        .policy_i(policy_i), .haddr_i(haddr_i), .prio_o(prio));

    ss_arb_len #(.NM(NM), .AW(AW), .CW(CW), .LEN_LSB(LEN_LSB)) len_i (
        .len_mode_i(len_mode_i), .hburst_i(hburst_i), .haddr_i(haddr_i),
        .len_o(len_all));

    ss_arb_pick #(.NM(NM), .PW(PW)) pick_i (
        .req_i(req_i), .prio_i(prio), .ptr_i(rr_ptr),
        .vld_o(pick_vld), .idx_o(pick_idx));

    assign cur_hsel  = hsel_i[cur_idx];
    assign cur_trans = htrans_i[cur_idx*2 +: 2];
    assign beat      = cur_vld && hready_i && cur_trans[1];
    assign cnt_dec   = (beat && cnt != '0) ? cnt - CW'(1) : cnt;

    // Next-state decision: lock, hold, expiry and early-release rules.
    always_comb begin
        nx_vld = cur_vld;
        nx_idx = cur_idx;
        nx_cnt = cnt;
        nx_ptr = rr_ptr;
        take   = 1'b0;
        if (!cur_vld)
            take = pick_vld;
        else if (hmastlock_i)
            nx_cnt = cnt_dec;
        else if (cnt != '0 && cur_hsel)
            nx_cnt = cnt_dec;
        else if (pick_vld)
            take = 1'b1;
        else if (!(cnt == '0 && cur_hsel)) begin
            nx_vld = 1'b0;
            nx_idx = '0;
            nx_cnt = '0;
        end
        if (take) begin
            nx_vld = 1'b1;
            nx_idx = pick_idx;
            nx_cnt = len_all[pick_idx*CW +: CW];
            nx_ptr = (int'(pick_idx) == NM - 1) ? '0 : pick_idx + IW'(1);
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_vld <= 1'b0;
            cur_idx <= '0;
            cnt     <= '0;
            rr_ptr  <= '0;
        end else begin
            cur_vld <= nx_vld;
            cur_idx <= nx_idx;
            cnt     <= nx_cnt;
            rr_ptr  <= nx_ptr;
        end
    end

    // Output decode of the registered grant.
    always_comb begin
        grant_o = '0;
        if (cur_vld) grant_o[cur_idx] = 1'b1;
    end
    assign master_o  = cur_idx;
    assign no_port_o = !cur_vld;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (no_port_o && grant_o == '0 && rr_ptr == '0)); // R1
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (no_port_o && req_i == '0) |=> no_port_o); // R2
    AST_IDLE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (no_port_o && req_i != '0) |=> !no_port_o); // R2
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_vld && hmastlock_i) |=> (cur_vld && $stable(cur_idx))); // R5
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_vld && cnt != '0 && cur_hsel) |=> (cur_vld && $stable(cur_idx))); // R6
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(16)); // R10
    AST_GRANT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && (no_port_o == (grant_o == '0))); // R7

endmodule

// File: tb/ss_arb_ctrl_tb_top.sv
// Bench: behavioural reference model advanced on every rising edge,
// compared with the design at each falling edge.
module ss_arb_ctrl_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   policy = 2'd1, lmode = 2'd0;
    logic [3:0]   req = '0, hsel = '0;
    logic         lock = 1'b0, hready = 1'b1;
    logic [1:0]   tr   [4];
    logic [2:0]   bu   [4];
    logic [31:0]  ad   [4];
    logic [7:0]   htrans;
    logic [11:0]  hburst;
    logic [127:0] haddr;
    logic [3:0]   grant;
    logic [1:0]   master;
    logic         no_port;

    int    vectors = 0, bad = 0;
    string tag = "R1";
    int    m_cur = -1, m_cnt = 0, m_ptr = 0;
    int    cyc = 0;

    for (genvar g = 0; g < 4; g++) begin : g_pack
        assign htrans[g*2 +: 2]  = tr[g];
        assign hburst[g*3 +: 3]  = bu[g];
        assign haddr[g*32 +: 32] = ad[g];
    end

    ss_arb_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .policy_i(policy), .len_mode_i(lmode),
        .req_i(req), .hsel_i(hsel), .hmastlock_i(lock), .hready_i(hready),
        .htrans_i(htrans), .hburst_i(hburst), .haddr_i(haddr),
        .grant_o(grant), .master_o(master), .no_port_o(no_port));

    always #4 clk = ~clk;

    function automatic int lvl(int m);
        int tbl[4] = '{4, 3, 2, 1};
        if (policy == 2'd0) return tbl[m];
        if (policy == 2'd1) return 0;
        return int'(ad[m][31:28]);
    endfunction

    function automatic int blen(int m);
        if (lmode == 2'd0) return 1;
        if (lmode == 2'd1) begin
            if (bu[m] >= 3'd6) return 16;
            if (bu[m] >= 3'd4) return 8;
            if (bu[m] >= 3'd2) return 4;
            return 1;
        end
        return (ad[m][27:24] == 4'd0) ? 1 : int'(ad[m][27:24]);
    endfunction

    function automatic int choose();
        int n = 0, best = -1, bp = -1, fp = -1;
        bit same = 1;
        for (int m = 0; m < 4; m++) if (req[m]) begin
            if (n == 0) fp = lvl(m);
            else if (lvl(m) != fp) same = 0;
            if (lvl(m) > bp) begin bp = lvl(m); best = m; end
            n++;
        end
        if (n == 0) return -1;
        if (!same) return best;
        for (int k = 0; k < 4; k++) if (req[(m_ptr + k) % 4]) return (m_ptr + k) % 4;
        return -1;
    endfunction

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        int w, dec;
        bit bt, sel;
        cyc++;
        if (!rst_n) begin
            m_cur = -1; m_cnt = 0; m_ptr = 0;
        end else begin
            w   = choose();
            bt  = (m_cur >= 0) && hready && tr[m_cur][1];
            dec = (bt && m_cnt > 0) ? m_cnt - 1 : m_cnt;
            sel = (m_cur >= 0) && hsel[m_cur];
            if (m_cur < 0 || !lock) begin
                if (m_cur >= 0 && m_cnt > 0 && sel) m_cnt = dec;
                else if (w >= 0) begin
                    m_cur = w; m_cnt = blen(w); m_ptr = (w + 1) % 4;
                end else if (m_cur >= 0 && !(m_cnt == 0 && sel)) begin
                    m_cur = -1; m_cnt = 0;
                end
            end else m_cnt = dec;
        end
    end

    task automatic compare();
        logic [3:0] eg;
        logic [1:0] em;
        eg = (m_cur < 0) ? 4'd0 : 4'(1 << m_cur);
        em = (m_cur < 0) ? 2'd0 : 2'(m_cur);
        vectors++;
        if (grant !== eg || master !== em || no_port !== (m_cur < 0)) begin
            bad++;
            $display("FAIL %s cyc %0d: grant=%b master=%0d no_port=%b expected grant=%b master=%0d no_port=%b",
                     tag, cyc, grant, master, no_port, eg, em, m_cur < 0);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic all_masters(logic [1:0] t, logic [2:0] b, logic [3:0] p, logic [3:0] l);
        for (int m = 0; m < 4; m++) begin
            tr[m] = t; bu[m] = b; ad[m] = {p, l, 24'h0};
        end
    endtask

    initial begin : watchdog
        #1600000;
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end

    initial begin
        all_masters(2'd2, 3'd0, 4'd0, 4'd0);
        tag = "R1"; step(3);               // R1 reset outputs
        rst_n = 1'b1;
        tag = "R2"; step(3);               // R2 idle stays idle
        req = 4'b1111; hsel = 4'b1111;
        tag = "R4"; policy = 2'd1; step(8);  // R4 round-robin rotation from 0
        req = 4'b0101; step(6);
        tag = "R3"; policy = 2'd2;         // R3 dynamic levels
        ad[1][31:28] = 4'd9; ad[3][31:28] = 4'd9; ad[2][31:28] = 4'd2;
        req = 4'b1110; step(5);
        policy = 2'd0; req = 4'b1100; step(4); // R3 fixed table
        tag = "R5"; req = 4'b1111; lock = 1'b1; step(6); // R5 lock
        lock = 1'b0;
        tag = "R10"; policy = 2'd1; lmode = 2'd1;
        for (int m = 0; m < 4; m++) bu[m] = 3'(2 * m + 1);
        step(2);
        tag = "R6"; hready = 1'b0; step(3);  // R6 no beats, hold
        hready = 1'b1; tr[0] = 2'd1; tr[1] = 2'd0; step(3); // BUSY/IDLE no beat
        tr[0] = 2'd3; tr[1] = 2'd3; tr[2] = 2'd3; tr[3] = 2'd3; step(20);
        tag = "R10"; lmode = 2'd2;
        for (int m = 0; m < 4; m++) ad[m][27:24] = 4'(m * 5);
        step(30);
        tag = "R7"; lmode = 2'd0; req = 4'b0010; step(3);
        req = 4'b0000; step(4);            // R7 expired, hsel high -> stay
        hsel = 4'b0000; step(3);           // R7 hsel low -> release
        tag = "R8"; hsel = 4'b1111; req = 4'b0001; lmode = 2'd2; step(2);
        req = 4'b1000; step(25);           // R8 expiry reselect
        tag = "R9"; req = 4'b0100; lmode = 2'd1; step(2);
        hsel = 4'b1011; step(3);           // R9 early finish with requester
        req = 4'b0000; hsel = 4'b1111; step(2);
        hsel = 4'b0000; step(3);           // R9 early finish alone -> release
        tag = "RAND";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            compare();
            req = 4'($urandom); hsel = 4'($urandom) | 4'($urandom);
            lock = ($urandom % 8) == 0; hready = ($urandom % 4) != 0;
            if ($urandom % 16 == 0) policy = 2'($urandom);
            if ($urandom % 16 == 0) lmode = 2'($urandom);
            for (int m = 0; m < 4; m++) begin
                tr[m] = 2'($urandom); bu[m] = 3'($urandom); ad[m] = $urandom;
            end
            if (i == 2000) begin rst_n = 1'b0; tag = "R1"; end
            if (i == 2003) begin rst_n = 1'b1; tag = "RAND"; end
        end
        step(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end

endmodule